// File: doc/BRIEF.md
# Byte-wide ALU with status flags

This block is the arithmetic and logic stage of a small 8-bit processor datapath. In a single combinational pass it produces the result of one operation on a destination operand and a source operand. The source operand is either the second register operand or an immediate. Alongside the result it gives the new values of six status flags and a per-flag write mask. The mask says which flags the operation defines. Every other flag keeps its previous value.

A flag register inside the block takes the masked flags on a clock edge when `exec_en` is high. The next operation reads the registered carry and zero flags from it, so chains such as multi-byte add, subtract and compare work with no outside help. A destination write-enable output tells the register file whether the result must be stored. Compares only update flags.

Top module: `alu8_core`

## Requirements
- R1: Flag vectors (`flag_new`, `flag_mask`, `flags_q`) use bit 5 = H, 4 = S, 3 = V, 2 = N, 1 = Z, 0 = C. Opcode 0 (add) and 1 (add with registered carry) return the low byte of the sum and write all six flags. C is the carry out of bit 7, H is the carry out of bit 3, V is signed overflow, N is bit 7 of the result and Z is set when the result is zero.
- R2: Opcode 2 (subtract), 3 (subtract with carry: destination minus source minus C), 4 (compare), 5 (compare with carry) and 6 (negate: 0x00 minus destination) write all six flags. C is the borrow out of bit 7, H is the borrow out of bit 3 and V is signed overflow of the difference.
- R3: For opcodes 3 and 5, Z becomes 0 when the result is nonzero and otherwise keeps its registered value.
- R4: Opcodes 7 (AND), 8 (OR) and 9 (XOR) write only S, V, N and Z (mask 0x1E). V is 0, and C and H keep their registered values.
- R5: Opcodes 11 (increment) and 12 (decrement) wrap modulo 256 and write mask 0x1E. V is set only for increment of 0x7F or decrement of 0x80.
- R6: Opcode 10 returns 0xFF minus the destination and writes mask 0x1F with C = 1 and V = 0.
- R7: Opcodes 13 (shift left, 0 into bit 0), 14 (logical shift right, 0 into bit 7), 15 (rotate left through C), 16 (rotate right through C) and 17 (arithmetic shift right, bit 7 kept) write mask 0x1F. C is the bit shifted out and V = N XOR C.
- R8: Opcode 18 swaps the two nibbles and opcode 19 returns 0xFF. Both leave the mask at 0.
- R9: Whenever S is written, it equals N XOR V of the same operation.
- R10: Reset clears `flags_q`. On a clock edge with `exec_en` high, exactly the masked bits of `flags_q` take `flag_new`. With `exec_en` low, `flags_q` holds.
- R11: `use_imm` high selects `imm` as the source operand. `dest_we` is 0 for compares (4, 5) and 1 for every other defined opcode.
- R12: Opcodes 20 to 31 return the destination operand unchanged, with mask 0 and `dest_we` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| exec_en | input | 1 | Commit masked flags on this edge |
| op | input | 5 | Operation code |
| opa | input | 8 | Destination operand |
| opb | input | 8 | Source register operand |
| imm | input | 8 | Immediate source operand |
| use_imm | input | 1 | Select immediate as source |
| result | output | 8 | Operation result |
| dest_we | output | 1 | Result should be written back |
| flag_new | output | 6 | Flag values computed by this operation |
| flag_mask | output | 6 | Flags this operation defines |
| flags_q | output | 6 | Registered status flags |

## Verification
The hardest situation to reach is the sticky zero flag. It matters only when the registered Z was set by an earlier committed operation and a later carry-chained subtract or compare gives a zero byte. Its effect also depends on whether the intermediate operations had `exec_en` high. The stimulus builds explicit two-byte compare chains: equal low bytes then equal high bytes, and unequal low bytes then equal high bytes. It also runs a long random stream with random commit strobes, so that the registered C and Z reach every chained opcode in both states. The reference model keeps its own copy of the flag register and checks every output in every cycle.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    typedef enum logic [4:0] {
        OP_ADD  = 5'd0,
        OP_ADC  = 5'd1,
        OP_SUB  = 5'd2,
        OP_SBC  = 5'd3,
        OP_CP   = 5'd4,
        OP_CPC  = 5'd5,
        OP_NEG  = 5'd6,
        OP_AND  = 5'd7,
        OP_OR   = 5'd8,
        OP_XOR  = 5'd9,
        OP_COM  = 5'd10,
        OP_INC  = 5'd11,
        OP_DEC  = 5'd12,
        OP_LSL  = 5'd13,
        OP_LSR  = 5'd14,
        OP_ROL  = 5'd15,
        OP_ROR  = 5'd16,
        OP_ASR  = 5'd17,
        OP_SWAP = 5'd18,
        OP_SER  = 5'd19
    } alu_op_e;

    localparam int FLAG_W = 6;

    typedef struct packed {
        logic h;
        logic s;
        logic v;
        logic n;
        logic z;
        logic c;
    } flags_t;

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
    parameter int W = 8
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         ci,
    input  logic         sub,
    output logic [W-1:0] r,
    output logic         co,
    output logic         hc,
    output logic         ov
);
    localparam int HB = W / 2;

    logic [W-1:0]  yy;
    logic          cin_eff;
    logic [W:0]    full;
    logic [HB:0]   low;

    always_comb begin
        // subtraction is x + ~y + ~borrow; carries then invert into borrows
        yy      = sub ? ~y : y;
        cin_eff = ci ^ sub;
        full    = {1'b0, x} + {1'b0, yy} + {{W{1'b0}}, cin_eff};
        low     = {1'b0, x[HB-1:0]} + {1'b0, yy[HB-1:0]} + {{HB{1'b0}}, cin_eff};
        r       = full[W-1:0];
        co      = full[W] ^ sub;
        hc      = low[HB] ^ sub;
        ov      = (x[W-1] == yy[W-1]) && (full[W-1] != x[W-1]);
    end

endmodule

// File: rtl/alu8_bitops.sv
module alu8_bitops
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  alu_op_e      opc,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] r,
    output logic         co
);
    localparam int HB = W / 2;

    always_comb begin
        r  = a;
        co = cin;
        case (opc)
            OP_AND:  r = a & b;
            OP_OR:   r = a | b;
            OP_XOR:  r = a ^ b;
            OP_COM:  r = ~a;
            OP_LSL:  begin r = {a[W-2:0], 1'b0};    co = a[W-1]; end
            OP_ROL:  begin r = {a[W-2:0], cin};     co = a[W-1]; end
            OP_LSR:  begin r = {1'b0, a[W-1:1]};    co = a[0];   end
            OP_ROR:  begin r = {cin, a[W-1:1]};     co = a[0];   end
            OP_ASR:  begin r = {a[W-1], a[W-1:1]};  co = a[0];   end
            OP_SWAP: r = {a[HB-1:0], a[W-1:HB]};
            OP_SER:  r = '1;
            default: r = a;
        endcase
    end

endmodule

// File: rtl/alu8_flagreg.sv
module alu8_flagreg #(
    parameter int FW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [FW-1:0] mask,
    input  logic [FW-1:0] nf,
    output logic [FW-1:0] flags_q
);
    logic [FW-1:0] flags_d;

    always_comb begin
        flags_d = flags_q;
        if (en) begin
            flags_d = (flags_q & ~mask) | (nf & mask);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            flags_q <= flags_d;
        end
    end

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(flags_q));

    // R10
    unmasked_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> (((flags_q ^ $past(flags_q)) & ~$past(mask)) == '0));

    // R9
    sign_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && mask[4]) |=> (flags_q[4] == (flags_q[3] ^ flags_q[2])));

endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         exec_en,
    input  logic [4:0]   op,
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    input  logic [W-1:0] imm,
    input  logic         use_imm,
    output logic [W-1:0] result,
    output logic         dest_we,
    output logic [5:0]   flag_new,
    output logic [5:0]   flag_mask,
    output logic [5:0]   flags_q
);
    localparam logic [W-1:0] ONE      = W'(1);
    localparam logic [W-1:0] POS_MAX  = {1'b0, {(W-1){1'b1}}};

    typedef struct packed {
        logic [W-1:0] res;
        flags_t       nf;
        flags_t       mk;
        logic         we;
    } alu_out_t;

    alu_op_e      opc;
    flags_t       fq;
    logic [W-1:0] src;

    logic [W-1:0] as_x, as_y, as_r;
    logic         as_ci, as_sub, as_co, as_h, as_v;
    logic [W-1:0] bo_r;
    logic         bo_c;

    alu_out_t     out_d;
    logic         sticky_z;

    assign opc = alu_op_e'(op);
    assign fq  = flags_t'(flags_q);
    assign src = use_imm ? imm : opb;

    always_comb begin
        as_x   = opa;
        as_y   = src;
        as_ci  = 1'b0;
        as_sub = 1'b0;
        case (opc)
            OP_ADC:         as_ci = fq.c;
            OP_SUB, OP_CP:  as_sub = 1'b1;
            OP_SBC, OP_CPC: begin as_sub = 1'b1; as_ci = fq.c; end
            OP_NEG:         begin as_x = '0; as_y = opa; as_sub = 1'b1; end
            OP_INC:         as_y = ONE;
            OP_DEC:         begin as_y = ONE; as_sub = 1'b1; end
            default:        as_ci = 1'b0;
        endcase
    end

    alu8_addsub #(.W(W)) addsub_i (
        .x   (as_x),
        .y   (as_y),
        .ci  (as_ci),
        .sub (as_sub),
        .r   (as_r),
        .co  (as_co),
        .hc  (as_h),
        .ov  (as_v)
    );

    alu8_bitops #(.W(W)) bitops_i (
        .opc (opc),
        .a   (opa),
        .b   (src),
        .cin (fq.c),
        .r   (bo_r),
        .co  (bo_c)
    );

    always_comb begin
        out_d     = '0;
        out_d.res = opa;
        sticky_z  = 1'b0;
        case (opc)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CP, OP_CPC, OP_NEG: begin
                out_d.res  = as_r;
                out_d.nf.h = as_h;
                out_d.nf.c = as_co;
                out_d.nf.v = as_v;
                out_d.mk   = flags_t'(6'b111111);
                out_d.we   = (opc != OP_CP) && (opc != OP_CPC);
                sticky_z   = (opc == OP_SBC) || (opc == OP_CPC);
            end
            OP_AND, OP_OR, OP_XOR: begin
                out_d.res  = bo_r;
                out_d.nf.v = 1'b0;
                out_d.mk   = flags_t'(6'b011110);
                out_d.we   = 1'b1;
            end
            OP_COM: begin
                out_d.res  = bo_r;
                out_d.nf.c = 1'b1;
                out_d.nf.v = 1'b0;
                out_d.mk   = flags_t'(6'b011111);
                out_d.we   = 1'b1;
            end
            OP_INC, OP_DEC: begin
                out_d.res  = as_r;
                out_d.nf.v = as_v;
                out_d.mk   = flags_t'(6'b011110);
                out_d.we   = 1'b1;
            end
            OP_LSL, OP_LSR, OP_ROL, OP_ROR, OP_ASR: begin
                out_d.res  = bo_r;
                out_d.nf.c = bo_c;
                out_d.nf.v = bo_r[W-1] ^ bo_c;
                out_d.mk   = flags_t'(6'b011111);
                out_d.we   = 1'b1;
            end
            OP_SWAP, OP_SER: begin
                out_d.res  = bo_r;
                out_d.we   = 1'b1;
            end
            default: out_d.res = opa;
        endcase
        out_d.nf.n = out_d.res[W-1];
        out_d.nf.z = (out_d.res == '0) && (!sticky_z || fq.z);
        out_d.nf.s = out_d.nf.n ^ out_d.nf.v;
    end

    alu8_flagreg #(.FW(FLAG_W)) flagreg_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (exec_en),
        .mask    (out_d.mk),
        .nf      (out_d.nf),
        .flags_q (flags_q)
    );

    assign result    = out_d.res;
    assign dest_we   = out_d.we;
    assign flag_new  = out_d.nf;
    assign flag_mask = out_d.mk;

    // R4
    logic_no_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((opc == OP_AND) || (opc == OP_OR) || (opc == OP_XOR))
            |-> (!flag_new[3] && !flag_mask[0] && !flag_mask[5]));

    // R5
    inc_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (opc == OP_INC) |-> (flag_new[3] == (opa == POS_MAX)));

    // R8
    swap_ser_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((opc == OP_SWAP) || (opc == OP_SER)) |-> (flag_mask == '0));

    // R11
    compare_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((opc == OP_CP) || (opc == OP_CPC)) |-> (!dest_we && (flag_mask == 6'b111111)));

    // R3
    sticky_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (((opc == OP_SBC) || (opc == OP_CPC)) && !flags_q[1]) |-> !flag_new[1]);

endmodule

// File: tb/alu8_core_tb.sv
`timescale 1ns/1ps
module alu8_core_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       exec_en = 1'b0;
    logic [4:0] op = '0;
    logic [7:0] opa = '0, opb = '0, imm = '0;
    logic       use_imm = 1'b0;
    logic [7:0] result;
    logic       dest_we;
    logic [5:0] flag_new, flag_mask, flags_q;

    int checks = 0;
    int errors = 0;
    int mflags = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    alu8_core dut_i (
        .clk(clk), .rst_n(rst_n), .exec_en(exec_en), .op(op),
        .opa(opa), .opb(opb), .imm(imm), .use_imm(use_imm),
        .result(result), .dest_we(dest_we), .flag_new(flag_new),
        .flag_mask(flag_mask), .flags_q(flags_q)
    );

    function automatic string tag_of(input int o);
        if (o <= 1) return "R1";
        if (o <= 6) return (o == 3 || o == 5) ? "R3" : "R2";
        if (o <= 9) return "R4";
        if (o == 10) return "R6";
        if (o <= 12) return "R5";
        if (o <= 17) return "R7";
        if (o <= 19) return "R8";
        return "R12";
    endfunction

    function automatic int sgn(input int x);
        return (x >= 128) ? x - 256 : x;
    endfunction

    // Behavioural model: returns result, flag values, mask and write-enable
    task automatic model(input int o, input int a, input int b, input int c, input int z,
                         output int r, output int nf, output int m, output int we);
        int d, sd, x, y, cc;
        int hh, vv, nn, zz, cy;
        hh = 0; vv = 0; cy = 0; m = 0; we = 1; r = a;
        case (o)
            0, 1: begin
                cc = (o == 1) ? c : 0;
                d = a + b + cc; r = d & 255; cy = (d > 255) ? 1 : 0;
                hh = (((a & 15) + (b & 15) + cc) > 15) ? 1 : 0;
                sd = sgn(a) + sgn(b) + cc; vv = (sd > 127 || sd < -128) ? 1 : 0;
                m = 63;
            end
            2, 3, 4, 5, 6: begin
                x = (o == 6) ? 0 : a; y = (o == 6) ? a : b;
                cc = (o == 3 || o == 5) ? c : 0;
                d = x - y - cc; r = d & 255; cy = (d < 0) ? 1 : 0;
                hh = (((x & 15) - (y & 15) - cc) < 0) ? 1 : 0;
                sd = sgn(x) - sgn(y) - cc; vv = (sd > 127 || sd < -128) ? 1 : 0;
                m = 63; we = (o == 4 || o == 5) ? 0 : 1;
            end
            7: begin r = a & b; m = 30; end
            8: begin r = a | b; m = 30; end
            9: begin r = a ^ b; m = 30; end
            10: begin r = 255 - a; cy = 1; m = 31; end
            11: begin r = (a + 1) & 255; vv = (a == 127) ? 1 : 0; m = 30; end
            12: begin r = (a + 255) & 255; vv = (a == 128) ? 1 : 0; m = 30; end
            13: begin r = (a * 2) & 255; cy = a / 128; m = 31; end
            15: begin r = ((a * 2) + c) & 255; cy = a / 128; m = 31; end
            14: begin r = a / 2; cy = a % 2; m = 31; end
            16: begin r = a / 2 + c * 128; cy = a % 2; m = 31; end
            17: begin r = a / 2 + (a & 128); cy = a % 2; m = 31; end
            18: begin r = (a % 16) * 16 + a / 16; end
            19: begin r = 255; end
            default: begin r = a; we = 0; end
        endcase
        nn = r / 128;
        zz = (r == 0) ? 1 : 0;
        if (o == 3 || o == 5) zz = zz & z;
        if (o >= 13 && o <= 17) vv = nn ^ cy;
        nf = hh * 32 + (nn ^ vv) * 16 + vv * 8 + nn * 4 + zz * 2 + cy;
    endtask

    task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic step(input int o, input int a, input int b, input int im, input bit ui, input bit ex);
        int r, nf, m, we, bsrc;
        @(negedge clk);
        op = o[4:0]; opa = a[7:0]; opb = b[7:0]; imm = im[7:0];
        use_imm = ui; exec_en = ex;
        #1;
        bsrc = ui ? im : b;
        model(o, a, bsrc, mflags % 2, (mflags / 2) % 2, r, nf, m, we);
        chk(int'(result) == r, tag_of(o), "result", result, r);
        chk(int'(flag_mask) == m, tag_of(o), "mask", flag_mask, m);
        chk((int'(flag_new) & m) == (nf & m), tag_of(o), "flags", int'(flag_new) & m, nf & m);
        chk(int'(dest_we) == we, "R11", "dest_we", dest_we, we);
        if ((m & 16) != 0)
            chk(flag_new[4] == (flag_new[3] ^ flag_new[2]), "R9", "sign", flag_new[4], flag_new[3] ^ flag_new[2]);
        chk(int'(flags_q) == mflags, "R10", "flags_q", flags_q, mflags);
        @(posedge clk);
        if (ex) mflags = (mflags & ~m) | (nf & m);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(flags_q == 6'd0, "R10", "reset flags", flags_q, 0);
        rst_n = 1'b1;
        // R1 add corners
        step(0, 8'h7F, 8'h01, 0, 0, 1);
        step(0, 8'hFF, 8'h01, 0, 0, 1);
        step(1, 8'h10, 8'h20, 0, 0, 1);
        // R2 subtract and negate corners
        step(2, 8'h00, 8'h01, 0, 0, 1);
        step(3, 8'h80, 8'h00, 0, 0, 1);
        step(6, 8'h80, 0, 0, 0, 1);
        step(6, 8'h00, 0, 0, 0, 1);
        // R3 two-byte compare chains: equal/equal then unequal/equal
        step(4, 8'h34, 8'h34, 0, 0, 1);
        step(5, 8'h12, 8'h12, 0, 0, 1);
        step(4, 8'h35, 8'h34, 0, 0, 1);
        step(5, 8'h12, 8'h12, 0, 0, 1);
        step(3, 8'h05, 8'h05, 0, 0, 1);
        // R4 logic ops keep carry (set carry first)
        step(2, 8'h00, 8'h01, 0, 0, 1);
        step(7, 8'hF0, 8'h0F, 0, 0, 1);
        step(9, 8'h80, 0, 8'h01, 1, 1);
        // R5 / R6
        step(11, 8'h7F, 0, 0, 0, 1);
        step(11, 8'hFF, 0, 0, 0, 1);
        step(12, 8'h80, 0, 0, 0, 1);
        step(12, 8'h00, 0, 0, 0, 1);
        step(10, 8'h5A, 0, 0, 0, 1);
        // R7 shifts and rotates
        step(15, 8'h80, 0, 0, 0, 1);
        step(16, 8'h01, 0, 0, 0, 1);
        step(17, 8'h81, 0, 0, 0, 1);
        step(14, 8'h81, 0, 0, 0, 1);
        step(13, 8'h40, 0, 0, 0, 1);
        // R8 / R12 / R11 immediate select
        step(18, 8'h3C, 0, 0, 0, 1);
        step(19, 8'h00, 0, 0, 0, 1);
        step(25, 8'hA5, 8'h11, 0, 0, 1);
        step(0, 8'h01, 8'h02, 8'h40, 1, 1);
        // R10 no commit with exec_en low
        step(6, 8'h01, 0, 0, 0, 0);
        step(0, 8'h00, 8'h00, 0, 0, 0);
        for (int i = 0; i < 3000; i++) begin
            step(int'($urandom_range(0, 23)), int'($urandom_range(0, 255)),
                 int'($urandom_range(0, 255)), int'($urandom_range(0, 255)),
                 1'($urandom_range(0, 1)), ($urandom_range(0, 3) != 0));
        end
        @(negedge clk);
        chk(int'(flags_q) == mflags, "R10", "final flags", flags_q, mflags);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule